// File: doc/BRIEF.md
# Affinity-Routed Software Interrupt Dispatcher

This block takes a 64-bit software interrupt request word from a requesting core and turns it into pending-set strobes for the selected cores. The word carries an interrupt number, a mode bit, a 16-bit bitmask indexed by the lowest affinity level, and three upper affinity fields. In broadcast mode, every core except the sender is a target. In targeted mode, a core is a target when its three upper affinity fields equal the requested ones and the bitmask bit selected by its lowest affinity field is set.

The block holds a table of per-core affinity values, supplied on an input port. It walks that table one core per clock, in ascending index order. While the walk runs, a busy flag refuses new requests. In targeted mode, each core that is served removes its bit from a working copy of the bitmask. The walk stops as soon as that copy becomes empty, or after the last core. A done pulse marks the end of every walk. A kick pulse accompanies it only when at least one core was marked pending. Holding the pending state and delivering it to the cores are handled elsewhere.

Top module: `sgi_dispatch`

## Requirements
- R1: Request word fields: bitmask in bits [15:0], level-1 affinity in [23:16], interrupt number in [27:24], level-2 affinity in [39:32], broadcast flag in bit 40, level-3 affinity in [55:48]; all other bits are ignored. Each core's table entry holds level 0 in bits [7:0], level 1 in [15:8], level 2 in [23:16] and level 3 in [31:24].
- R2: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the following cycle until the walk ends. A request presented while `busy` is high has no effect.
- R3: The walk visits core 0 in the first busy cycle, then one core per cycle in ascending order. `pend_set` has at most one bit set, only for the core being visited, and `pend_id` shows the accepted interrupt number while a bit is set.
- R4: With the broadcast flag set, every core except the requester is marked.
- R5: With the broadcast flag clear, a core is marked only if its levels 1 to 3 equal the requested ones and its level-0 value is below 16 with that bitmask bit set. Bitmask bits naming no existing core are never matched.
- R6: In targeted mode, serving a core clears its level-0 bit from the working bitmask, so a later core with the same affinity is not marked.
- R7: In targeted mode, a busy cycle that finds the working bitmask empty marks no core and ends the walk. This includes a request whose bitmask is zero on entry.
- R8: If the walk does not end early, it ends in the cycle that visits the last core.
- R9: `done` pulses for one cycle in the cycle after the walk's last busy cycle, with `busy` low. `kick` pulses with it only if the walk marked at least one core.
- R10: After reset, `busy`, `pend_set`, `done` and `kick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_word | input | 64 | Software interrupt request word |
| req_core | input | CIDX_W | Index of the requesting core |
| core_aff | input | NUM_CORES*32 | Per-core affinity table |
| busy | output | 1 | Walk in progress; requests refused |
| pend_set | output | NUM_CORES | Per-core pending-set strobe |
| pend_id | output | 4 | Interrupt number for the strobes |
| done | output | 1 | End-of-walk pulse |
| kick | output | 1 | At least one core was marked |

## Verification
The bench builds the block with NUM_CORES = 6. This makes every walk short. It also leaves bitmask bits 6 to 15 pointing at no existing core. The bench rewrites the affinity table between scenarios. That lets it set up two clusters, give two cores the same affinity so the served-bit clearing and early exit both show up, and let a broadcast come from the last core. A behavioural model predicts `busy`, `pend_set`, `pend_id`, `done` and `kick` on every cycle. Per-walk totals check the set of marked cores and the walk length.

// File: rtl/sgi_disp_pkg.sv
package sgi_disp_pkg;
  localparam int LIST_W = 16;
  localparam int ID_W   = 4;
  localparam int AFF_W  = 8;

  // Bit positions inside the request word (decoded by the requesting side too)
  localparam int POS_LIST  = 0;
  localparam int POS_AFF1  = 16;
  localparam int POS_ID    = 24;
  localparam int POS_AFF2  = 32;
  localparam int POS_BCAST = 40;
  localparam int POS_AFF3  = 48;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              bcast;
    logic [LIST_W-1:0] tlist;
    logic [AFF_W-1:0]  a1;
    logic [AFF_W-1:0]  a2;
    logic [AFF_W-1:0]  a3;
  } sgi_req_t;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WALK = 1'b1} walk_st_e;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_disp_pkg::*;
(
  input  logic [63:0] word,
  output sgi_req_t    req
);
  always_comb begin
    req.tlist = word[POS_LIST  +: LIST_W];
    req.a1    = word[POS_AFF1  +: AFF_W];
    req.id    = word[POS_ID    +: ID_W];
    req.a2    = word[POS_AFF2  +: AFF_W];
    req.bcast = word[POS_BCAST];
    req.a3    = word[POS_AFF3  +: AFF_W];
  end
endmodule

// File: rtl/sgi_core_match.sv
module sgi_core_match
  import sgi_disp_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int CIDX_W    = 3
) (
  input  sgi_req_t                 req,
  input  logic [LIST_W-1:0]        wlist,
  input  logic [CIDX_W-1:0]        src_core,
  input  logic [NUM_CORES*32-1:0]  core_aff,
  output logic [NUM_CORES-1:0]     hit_vec
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [AFF_W-1:0] l0, l1, l2, l3;
    logic             upper_eq, in_list;
    assign l0 = core_aff[c*32 +  0 +: AFF_W];
    assign l1 = core_aff[c*32 +  8 +: AFF_W];
    assign l2 = core_aff[c*32 + 16 +: AFF_W];
    assign l3 = core_aff[c*32 + 24 +: AFF_W];
    assign upper_eq = (l1 == req.a1) && (l2 == req.a2) && (l3 == req.a3);
    assign in_list  = (l0 < AFF_W'(LIST_W)) && wlist[l0[3:0]];
    always_comb begin
      if (req.bcast) hit_vec[c] = (CIDX_W'(c) != src_core);
      else           hit_vec[c] = upper_eq && in_list;
    end
  end
endmodule

// File: rtl/sgi_walk_ctrl.sv
module sgi_walk_ctrl
  import sgi_disp_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int CIDX_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LIST_W-1:0]    start_list,
  input  logic                 bcast,
  input  logic [NUM_CORES-1:0] hit_vec,
  input  logic [3:0]           cur_l0,
  input  logic                 cur_l0_ok,
  output logic                 busy,
  output logic [CIDX_W-1:0]    idx,
  output logic [LIST_W-1:0]    wlist,
  output logic                 cur_hit,
  output logic                 done,
  output logic                 kick
);
  localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(NUM_CORES - 1);

  walk_st_e          st_q, st_d;
  logic [CIDX_W-1:0] idx_q, idx_d;
  logic [LIST_W-1:0] list_q, list_d;
  logic              any_q, any_d;
  logic              done_q, done_d;
  logic              kick_q, kick_d;
  logic              walking, list_empty, finish;

  assign walking    = (st_q == ST_WALK);
  assign list_empty = walking && !bcast && (list_q == '0);
  assign cur_hit    = walking && !list_empty && hit_vec[idx_q];
  assign finish     = walking && (list_empty || idx_q == LAST_IDX);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    list_d = list_q;
    any_d  = any_q;
    done_d = finish;
    kick_d = finish && (any_q || cur_hit);
    if (!walking) begin
      if (start) begin
        st_d   = ST_WALK;
        idx_d  = '0;
        list_d = start_list;
        any_d  = 1'b0;
      end
    end else begin
      if (cur_hit) any_d = 1'b1;
      if (cur_hit && !bcast && cur_l0_ok) list_d[cur_l0] = 1'b0;
      if (finish) st_d = ST_IDLE;
      else        idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      list_q <= '0;
      any_q  <= 1'b0;
      done_q <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      list_q <= list_d;
      any_q  <= any_d;
      done_q <= done_d;
      kick_q <= kick_d;
    end
  end

  assign busy  = walking;
  assign idx   = idx_q;
  assign wlist = list_q;
  assign done  = done_q;
  assign kick  = kick_q;

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_kick_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> done);
  assert_list_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((list_q & ~$past(list_q)) == '0));
  assert_walk_starts_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (idx_q == '0));
  assert_empty_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bcast && list_q == '0) |=> !busy);
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_disp_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int CIDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [63:0]             req_word,
  input  logic [CIDX_W-1:0]       req_core,
  input  logic [NUM_CORES*32-1:0] core_aff,
  output logic                    busy,
  output logic [NUM_CORES-1:0]    pend_set,
  output logic [ID_W-1:0]         pend_id,
  output logic                    done,
  output logic                    kick
);
  // Reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_s2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  sgi_req_t          dec_req, req_q, req_d;
  logic [CIDX_W-1:0] src_q, src_d;
  logic              accept;
  logic [NUM_CORES-1:0] hit_vec;
  logic [CIDX_W-1:0] idx;
  logic [LIST_W-1:0] wlist;
  logic              cur_hit;
  logic [AFF_W-1:0]  cur_l0_full;
  logic              walk_busy;

  sgi_req_decode u_dec (.word(req_word), .req(dec_req));

  assign accept = req_valid && !walk_busy;

  always_comb begin
    req_d = req_q;
    src_d = src_q;
    if (accept) begin
      req_d = dec_req;
      src_d = req_core;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      req_q <= '0;
      src_q <= '0;
    end else begin
      req_q <= req_d;
      src_q <= src_d;
    end
  end

  sgi_core_match #(.NUM_CORES(NUM_CORES), .CIDX_W(CIDX_W)) u_match (
    .req      (req_q),
    .wlist    (wlist),
    .src_core (src_q),
    .core_aff (core_aff),
    .hit_vec  (hit_vec)
  );

  assign cur_l0_full = core_aff[idx*32 +: AFF_W];

  sgi_walk_ctrl #(.NUM_CORES(NUM_CORES), .CIDX_W(CIDX_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (accept),
    .start_list (dec_req.tlist),
    .bcast      (req_q.bcast),
    .hit_vec    (hit_vec),
    .cur_l0     (cur_l0_full[3:0]),
    .cur_l0_ok  (cur_l0_full < AFF_W'(LIST_W)),
    .busy       (walk_busy),
    .idx        (idx),
    .wlist      (wlist),
    .cur_hit    (cur_hit),
    .done       (done),
    .kick       (kick)
  );

  always_comb begin
    pend_set = '0;
    if (cur_hit) pend_set[idx] = 1'b1;
  end
  assign pend_id = req_q.id;
  assign busy    = walk_busy;

  assert_pend_onehot_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(pend_set));
  assert_pend_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pend_set != '0) |-> busy);
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && req_valid) |=> ($stable(req_q) && $stable(src_q)));
  assert_skip_sender_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && req_q.bcast) |-> !pend_set[src_q]);
endmodule

// File: tb/sim_sgi_dispatch.sv
module sim_sgi_dispatch;
  localparam int N  = 6;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [63:0]   req_word = '0;
  logic [CW-1:0] req_core = '0;
  logic [N*32-1:0] core_aff = '0;
  logic          busy, done, kick;
  logic [N-1:0]  pend_set;
  logic [3:0]    pend_id;

  always #5 clk = ~clk;

  sgi_dispatch #(.NUM_CORES(N), .CIDX_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .req_core(req_core), .core_aff(core_aff), .busy(busy), .pend_set(pend_set),
    .pend_id(pend_id), .done(done), .kick(kick));

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int id, input bit bc, input int lst,
                                     input int a1, input int a2, input int a3);
    return {8'h00, 8'(a3), 7'h00, bc, 8'(a2), 4'h0, 4'(id), 8'(a1), 16'(lst)};
  endfunction

  task automatic set_aff(input int c, input int a0, input int a1, input int a2, input int a3);
    core_aff[c*32 +: 32] = {8'(a3), 8'(a2), 8'(a1), 8'(a0)};
  endtask

  // Behavioural reference model
  bit m_run = 0, m_busy = 0, m_bc = 0, m_any = 0, m_done = 0, m_kick = 0;
  int m_idx = 0, m_req = 0, m_id = 0, m_a1 = 0, m_a2 = 0, m_a3 = 0;
  bit [15:0] m_list = 0;

  function automatic bit m_hit(input int c);
    int a0, a1, a2, a3;
    a0 = int'(core_aff[c*32 +: 8]);  a1 = int'(core_aff[c*32+8 +: 8]);
    a2 = int'(core_aff[c*32+16 +: 8]); a3 = int'(core_aff[c*32+24 +: 8]);
    if (m_bc) return c != m_req;
    return a1 == m_a1 && a2 == m_a2 && a3 == m_a3 && a0 < 16 && m_list[a0];
  endfunction

  // Per-walk accumulators
  logic [N-1:0] acc_mask = '0;
  int  acc_busy = 0;
  bit  seen_done = 0, seen_kick = 0;

  always @(negedge clk) if (m_run) begin
    bit empty, sel, fin;
    logic [N-1:0] exp_p;
    empty = m_busy && !m_bc && (m_list == 0);
    sel   = m_busy && !empty && m_hit(m_idx);
    exp_p = '0;
    if (sel) exp_p[m_idx] = 1'b1;
    check(busy == m_busy, "R2 busy", busy, m_busy);
    check(pend_set == exp_p, "R3 pend_set", pend_set, exp_p);
    check(done == m_done, "R9 done", done, m_done);
    check(kick == m_kick, "R9 kick", kick, m_kick);
    if (pend_set != 0) check(pend_id == 4'(m_id), "R1 pend_id", pend_id, m_id);
    acc_mask |= pend_set;
    if (busy) acc_busy++;
    if (done) seen_done = 1;
    if (kick) seen_kick = 1;
    if (m_busy) begin
      fin = empty || (m_idx == N-1);
      m_done = fin;
      m_kick = fin && (m_any || sel);
      if (sel) m_any = 1;
      if (sel && !m_bc) m_list[int'(core_aff[m_idx*32 +: 4])] = 1'b0;
      if (fin) m_busy = 0; else m_idx++;
    end else begin
      m_done = 0; m_kick = 0;
      if (req_valid) begin
        m_busy = 1; m_idx = 0; m_any = 0;
        m_list = req_word[15:0]; m_a1 = int'(req_word[23:16]);
        m_id = int'(req_word[27:24]); m_a2 = int'(req_word[39:32]);
        m_bc = req_word[40]; m_a3 = int'(req_word[55:48]);
        m_req = int'(req_core);
      end
    end
  end

  task automatic run_req(input logic [63:0] w, input int src, input logic [N-1:0] exp_mask,
                         input int exp_len, input bit exp_kick, input string tag);
    while (busy) begin @(posedge clk); #1; end
    acc_mask = '0; acc_busy = 0; seen_done = 0; seen_kick = 0;
    req_valid = 1'b1; req_word = w; req_core = CW'(src);
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!seen_done) @(negedge clk);
    @(posedge clk); #1;
    check(acc_mask == exp_mask, {tag, " marked set"}, acc_mask, exp_mask);
    check(acc_busy == exp_len, {tag, " walk length"}, acc_busy, exp_len);
    check(seen_kick == exp_kick, {tag, " kick"}, seen_kick, exp_kick);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    set_aff(0, 0, 0, 0, 0); set_aff(1, 1, 0, 0, 0);
    set_aff(2, 2, 0, 0, 0); set_aff(3, 3, 0, 0, 0);
    set_aff(4, 0, 1, 0, 0); set_aff(5, 1, 1, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(busy == 0 && pend_set == 0 && done == 0 && kick == 0, "R10 reset outputs",
          {busy, pend_set, done, kick}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    m_run = 1;
    // R4: broadcast from core 2, whole table walked (R8)
    run_req(mk(5, 1, 0, 0, 0, 0), 2, 6'b111011, 6, 1, "R4");
    // R4: broadcast from the last core
    run_req(mk(9, 1, 16'hFFFF, 7, 7, 7), 5, 6'b011111, 6, 1, "R4 last sender");
    // R5/R7: cores 0 and 2 of cluster 0, early exit at core 3
    run_req(mk(3, 0, 16'h0005, 0, 0, 0), 0, 6'b000101, 4, 1, "R7 early exit");
    // R8: core 5 only, walk reaches the end; R1 interrupt number 0xA
    run_req(mk(10, 0, 16'h0002, 1, 0, 0), 1, 6'b100000, 6, 1, "R8 full walk");
    // R5: bits for absent cores never match
    run_req(mk(1, 0, 16'hFF00, 0, 0, 0), 3, 6'b000000, 6, 0, "R5 absent bits");
    // R5: level 2/3 mismatch, field bits outside fields set (R1)
    run_req(mk(2, 0, 16'h000F, 0, 1, 0) | 64'hFF00_FE00_F000_0000, 0, 6'b000000, 6, 0, "R5 upper mismatch");
    // R7: empty bitmask on entry
    run_req(mk(4, 0, 0, 0, 0, 0), 0, 6'b000000, 1, 0, "R7 empty entry");
    // R6: duplicate affinity, only the first core is marked
    set_aff(1, 0, 0, 0, 0);
    run_req(mk(6, 0, 16'h0001, 0, 0, 0), 4, 6'b000001, 2, 1, "R6 duplicate");
    set_aff(1, 1, 0, 0, 0);
    // R2: request while busy is ignored
    while (busy) begin @(posedge clk); #1; end
    acc_mask = '0; acc_busy = 0; seen_done = 0;
    req_valid = 1'b1; req_word = mk(7, 1, 0, 0, 0, 0); req_core = 3'd0;
    @(posedge clk); #1;
    req_word = mk(12, 0, 16'h0001, 1, 0, 0); req_core = 3'd4;
    repeat (3) @(posedge clk);
    #1;
    req_valid = 1'b0;
    while (!seen_done) @(negedge clk);
    @(posedge clk); #1;
    check(acc_mask == 6'b111110, "R2 busy request ignored", acc_mask, 6'b111110);
    check(pend_id == 4'd7, "R2 id kept", pend_id, 7);
    repeat (8) @(posedge clk);
    #1;
    check(busy == 0, "R2 no late start", busy, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule